// File: doc/BRIEF.md
# Iterative ARX Block Cipher Core

This core encrypts or decrypts one 128-bit block. The block is held as four 32-bit words A, B, C and D. The cipher runs 20 rounds. Each round takes one clock. A round feeds a word through the quadratic map f(X) = X·(2X+1) mod 2^32 and rotates the result left by 5. The two values this gives set data-dependent rotation amounts for the other two words. The round also uses XOR and modular add (encryption) or subtract (decryption). At the end of each round the four words change places.

The 44 round keys live in an external synchronous key store, which the core reads one pair per step. Pair index k selects the two words S[2k] and S[2k+1]. The core drives the index of the pair it will need one cycle before it uses that pair, so a store with a one-cycle read latency fits with no glue logic.

To start an operation, pulse the start input for one cycle. That same cycle must carry the input block and the mode. When the result is ready the core raises done for one cycle. The result then stays on the output until the next operation completes.

Top module: `arx_block_core`

## Requirements
- R1: While reset is high and in the first cycle after it is released, done_o is 0, blk_o is all zeros and key_idx_o is 0.
- R2: Encryption (decrypt_i = 0) first adds S[0] to B and S[1] to D. Its last step adds S[42] to A and S[43] to C.
- R3: Encryption round i (1 to 20) sets t = rotl(f(B),5) and u = rotl(f(D),5). It then sets A = rotl(A^t, u mod 32) + S[2i] and C = rotl(C^u, t mod 32) + S[2i+1]. Finally the words move as (A,B,C,D) ← (B,C,D,A).
- R4: Decryption (decrypt_i = 1) first subtracts S[43] from C and S[42] from A. It then runs rounds i = 20 down to 1. Each round first moves the words as (A,B,C,D) ← (D,A,B,C). It then sets C = rotr(C − S[2i+1], t) ^ u and A = rotr(A − S[2i], u) ^ t, with t and u formed from B and D as in R3. The last step subtracts S[1] from D and S[0] from B.
- R5: Decrypting the encryption result of a block under the same round keys gives back the original block.
- R6: Block packing: A is blk[31:0], B is blk[63:32], C is blk[95:64] and D is blk[127:96]. All arithmetic is mod 2^32. Rotations use only bits [4:0] of the controlling word.
- R7: key_idx_o = k requests key_pair_i = {S[2k+1], S[2k]}, which the store returns one cycle later. After the accepting edge, key_idx_o is 0 then 1 when encrypting, and 21 then 20 when decrypting.
- R8: done_o rises in the 24th cycle counted from the cycle after the edge that accepted start, and it is high for exactly one cycle.
- R9: blk_o changes only in the cycle in which done_o is high. It then holds its value until the next operation completes.
- R10: A start pulse that arrives while an operation is in progress is ignored. The running operation finishes with its own block and mode.
- R11: With all 44 round keys zero, an all-zero block encrypts and decrypts to an all-zero block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, sampled only when idle |
| decrypt_i | input | 1 | Mode: 0 encrypt, 1 decrypt |
| blk_i | input | 128 | Input block {D,C,B,A} |
| key_idx_o | output | 5 | Round-key pair index requested from the store |
| key_pair_i | input | 64 | {S[2k+1], S[2k]} for the index of the previous cycle |
| blk_o | output | 128 | Result block {D,C,B,A} |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A result is due 24 cycles after its start pulse. That is 23 clock edges after the accepting edge: one prime cycle for the key store, then 22 steps, and then the output register. The bench drives start at a falling edge and counts falling edges until done appears. It fails any operation whose count is not exactly 24, and it samples blk_o at that same falling edge. The bench checks the key index in the first two cycles after acceptance, because the store answers one cycle after it sees an index. It checks done and blk_o again one cycle and several cycles after completion, to confirm the pulse width and that the result holds.

// File: rtl/arx_pkg.sv
package arx_pkg;

    localparam int WORD_W = 32;
    localparam int ROT_W  = $clog2(WORD_W);
    localparam int BLK_W  = 4 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ROT_W-1:0]  rot_t;

    // Field order sets packing: a sits in the low word, d in the high word.
    typedef struct packed {
        word_t d;
        word_t c;
        word_t b;
        word_t a;
    } blk_t;

    typedef enum logic [1:0] {PH_IN, PH_ROUND, PH_OUT} phase_t;
    typedef enum logic [1:0] {ST_IDLE, ST_PRIME, ST_RUN} state_t;

    function automatic word_t rotl(word_t x, rot_t n);
        logic [2*WORD_W-1:0] dbl;
        dbl = {x, x} << n;
        return dbl[2*WORD_W-1:WORD_W];
    endfunction

    function automatic word_t rotr(word_t x, rot_t n);
        logic [2*WORD_W-1:0] dbl;
        dbl = {x, x} >> n;
        return dbl[WORD_W-1:0];
    endfunction

    // x*(2x+1) truncated to one word, then rotated by log2 of the word width
    function automatic word_t mix(word_t x);
        word_t odd;
        word_t prod;
        odd  = {x[WORD_W-2:0], 1'b1};
        prod = x * odd;
        return rotl(prod, rot_t'(ROT_W));
    endfunction

endpackage

// File: rtl/arx_step.sv
module arx_step
    import arx_pkg::*;
(
    input  blk_t   cur_i,
    input  word_t  k_lo_i,
    input  word_t  k_hi_i,
    input  logic   dec_i,
    input  phase_t phase_i,
    output blk_t   nxt_o
);

    word_t t_w;
    word_t u_w;
    word_t new_a;
    word_t new_c;

    // Decryption reads B,D after the word swap, i.e. the current A and C.
    always_comb begin
        if (dec_i) begin
            t_w = mix(cur_i.a);
            u_w = mix(cur_i.c);
        end else begin
            t_w = mix(cur_i.b);
            u_w = mix(cur_i.d);
        end
    end

    always_comb begin
        if (dec_i) begin
            new_c = rotr(cur_i.b - k_hi_i, t_w[ROT_W-1:0]) ^ u_w;
            new_a = rotr(cur_i.d - k_lo_i, u_w[ROT_W-1:0]) ^ t_w;
        end else begin
            new_a = rotl(cur_i.a ^ t_w, u_w[ROT_W-1:0]) + k_lo_i;
            new_c = rotl(cur_i.c ^ u_w, t_w[ROT_W-1:0]) + k_hi_i;
        end
    end

    always_comb begin
        nxt_o = cur_i;
        unique case (phase_i)
            PH_IN: begin
                if (dec_i) begin
                    nxt_o.c = cur_i.c - k_hi_i;
                    nxt_o.a = cur_i.a - k_lo_i;
                end else begin
                    nxt_o.b = cur_i.b + k_lo_i;
                    nxt_o.d = cur_i.d + k_hi_i;
                end
            end
            PH_ROUND: begin
                if (dec_i) begin
                    nxt_o.a = new_a;
                    nxt_o.b = cur_i.a;
                    nxt_o.c = new_c;
                    nxt_o.d = cur_i.c;
                end else begin
                    nxt_o.a = cur_i.b;
                    nxt_o.b = new_c;
                    nxt_o.c = cur_i.d;
                    nxt_o.d = new_a;
                end
            end
            PH_OUT: begin
                if (dec_i) begin
                    nxt_o.d = cur_i.d - k_hi_i;
                    nxt_o.b = cur_i.b - k_lo_i;
                end else begin
                    nxt_o.a = cur_i.a + k_lo_i;
                    nxt_o.c = cur_i.c + k_hi_i;
                end
            end
            default: nxt_o = cur_i;
        endcase
    end

endmodule

// File: rtl/arx_seq.sv
module arx_seq
    import arx_pkg::*;
#(
    parameter  int ROUNDS = 20,
    localparam int IDX_W  = $clog2(ROUNDS + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             dec_i,
    output logic             accept_o,
    output logic             apply_o,
    output logic             last_o,
    output logic             busy_o,
    output logic             dec_o,
    output phase_t           phase_o,
    output logic [IDX_W-1:0] key_idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROUNDS + 1);

    state_t           state_q;
    logic [IDX_W-1:0] step_q;
    logic             dec_q;
    logic [IDX_W-1:0] key_idx_q;

    function automatic logic [IDX_W-1:0] pair_of(logic d, logic [IDX_W-1:0] s);
        return d ? (LAST_IDX - s) : s;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            step_q    <= '0;
            dec_q     <= 1'b0;
            key_idx_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dec_q     <= dec_i;
                        step_q    <= '0;
                        key_idx_q <= pair_of(dec_i, '0);
                        state_q   <= ST_PRIME;
                    end
                end
                ST_PRIME: begin
                    key_idx_q <= pair_of(dec_q, IDX_W'(1));
                    state_q   <= ST_RUN;
                end
                ST_RUN: begin
                    if (step_q == LAST_IDX) begin
                        state_q <= ST_IDLE;
                    end else begin
                        step_q <= step_q + IDX_W'(1);
                        if (step_q + IDX_W'(1) != LAST_IDX) begin
                            key_idx_q <= pair_of(dec_q, step_q + IDX_W'(2));
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign accept_o  = (state_q == ST_IDLE) && start_i;
    assign apply_o   = (state_q == ST_RUN);
    assign last_o    = (state_q == ST_RUN) && (step_q == LAST_IDX);
    assign busy_o    = (state_q != ST_IDLE);
    assign dec_o     = dec_q;
    assign key_idx_o = key_idx_q;
    assign phase_o   = (step_q == '0)      ? PH_IN  :
                       (step_q == LAST_IDX) ? PH_OUT : PH_ROUND;

    assert_first_key_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_i) |=> (key_idx_o == ($past(dec_i) ? LAST_IDX : '0)));

    assert_key_range_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |-> (key_idx_o <= LAST_IDX));

    assert_run_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN && step_q != LAST_IDX) |=> (state_q == ST_RUN && $stable(dec_q)));

endmodule

// File: rtl/arx_block_core.sv
module arx_block_core
    import arx_pkg::*;
#(
    parameter  int ROUNDS = 20,
    localparam int IDX_W  = $clog2(ROUNDS + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               decrypt_i,
    input  logic [BLK_W-1:0]   blk_i,
    output logic [IDX_W-1:0]   key_idx_o,
    input  logic [2*WORD_W-1:0] key_pair_i,
    output logic [BLK_W-1:0]   blk_o,
    output logic               done_o
);

    logic   accept;
    logic   apply;
    logic   last;
    logic   busy;
    logic   dec;
    phase_t phase;
    blk_t   work_q;
    blk_t   out_q;
    blk_t   nxt;
    logic   done_q;

    arx_seq #(.ROUNDS(ROUNDS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .dec_i     (decrypt_i),
        .accept_o  (accept),
        .apply_o   (apply),
        .last_o    (last),
        .busy_o    (busy),
        .dec_o     (dec),
        .phase_o   (phase),
        .key_idx_o (key_idx_o)
    );

    arx_step u_step (
        .cur_i   (work_q),
        .k_lo_i  (key_pair_i[WORD_W-1:0]),
        .k_hi_i  (key_pair_i[2*WORD_W-1:WORD_W]),
        .dec_i   (dec),
        .phase_i (phase),
        .nxt_o   (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            work_q <= '0;
            out_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (accept) begin
                work_q <= blk_t'(blk_i);
            end else if (apply) begin
                work_q <= nxt;
            end
            if (last) begin
                out_q <= nxt;
            end
        end
    end

    assign blk_o  = out_q;
    assign done_o = done_q;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy);

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(blk_o) |-> done_o);

endmodule

// File: tb/test_arx_block_core.sv
`timescale 1ns/1ps
module test_arx_block_core;

    localparam int NR = 20;
    localparam int NK = 2 * NR + 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         decrypt = 1'b0;
    logic [127:0] blk_in = '0;
    logic [4:0]   key_idx;
    logic [63:0]  key_pair = '0;
    logic [127:0] blk_out;
    logic         done;

    logic [31:0] rk [NK];

    int checks = 0;
    int errors = 0;
    logic [4:0] idx_first;
    logic [4:0] idx_second;

    always #5 clk = ~clk;

    arx_block_core i_arx_block_core (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .decrypt_i  (decrypt),
        .blk_i      (blk_in),
        .key_idx_o  (key_idx),
        .key_pair_i (key_pair),
        .blk_o      (blk_out),
        .done_o     (done)
    );

    // Synchronous round-key store, one cycle read latency
    always_ff @(posedge clk) begin
        if (key_idx <= 5'd21) begin
            key_pair <= {rk[2*key_idx+1], rk[2*key_idx]};
        end
    end

    localparam logic [127:0] VEC [6] = '{
        128'h0,
        128'hffffffff_ffffffff_ffffffff_ffffffff,
        128'h01234567_89abcdef_fedcba98_76543210,
        128'h80000000_00000001_7fffffff_fffffffe,
        128'h55555555_aaaaaaaa_33333333_cccccccc,
        128'h00000001_00000000_00000000_00000000
    };

    function automatic logic [31:0] m_rol(logic [31:0] x, int n);
        int s = n & 31;
        if (s == 0) return x;
        return (x << s) | (x >> (32 - s));
    endfunction

    function automatic logic [31:0] m_ror(logic [31:0] x, int n);
        int s = n & 31;
        if (s == 0) return x;
        return (x >> s) | (x << (32 - s));
    endfunction

    function automatic logic [31:0] m_quad(logic [31:0] x);
        logic [31:0] r;
        r = x * ((x << 1) + 32'd1);
        return r;
    endfunction

    function automatic logic [127:0] ref_enc(logic [127:0] p);
        logic [31:0] a, b, c, d, t, u, tmp;
        a = p[31:0]; b = p[63:32]; c = p[95:64]; d = p[127:96];
        b = b + rk[0];
        d = d + rk[1];
        for (int i = 1; i <= NR; i++) begin
            t = m_rol(m_quad(b), 5);
            u = m_rol(m_quad(d), 5);
            a = m_rol(a ^ t, int'(u[4:0])) + rk[2*i];
            c = m_rol(c ^ u, int'(t[4:0])) + rk[2*i+1];
            tmp = a; a = b; b = c; c = d; d = tmp;
        end
        a = a + rk[2*NR+2];
        c = c + rk[2*NR+3];
        return {d, c, b, a};
    endfunction

    function automatic logic [127:0] ref_dec(logic [127:0] p);
        logic [31:0] a, b, c, d, t, u, tmp;
        a = p[31:0]; b = p[63:32]; c = p[95:64]; d = p[127:96];
        c = c - rk[2*NR+3];
        a = a - rk[2*NR+2];
        for (int i = NR; i >= 1; i--) begin
            tmp = d; d = c; c = b; b = a; a = tmp;
            u = m_rol(m_quad(d), 5);
            t = m_rol(m_quad(b), 5);
            c = m_ror(c - rk[2*i+1], int'(t[4:0])) ^ u;
            a = m_ror(a - rk[2*i], int'(u[4:0])) ^ t;
        end
        d = d - rk[1];
        b = b - rk[0];
        return {d, c, b, a};
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill_keys(input bit zero);
        for (int j = 0; j < NK; j++) rk[j] = zero ? 32'h0 : $urandom;
    endtask

    // Runs one operation; returns result and the falling-edge count to done.
    task automatic run_op(input logic dec, input logic [127:0] blk, input bit poke,
                          output logic [127:0] res, output int lat);
        @(negedge clk);
        start = 1'b1; decrypt = dec; blk_in = blk;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        idx_first = key_idx;
        while (!done && lat < 40) begin
            if (poke && lat == 5) begin
                start = 1'b1; decrypt = ~dec; blk_in = ~blk;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
            if (lat == 2) idx_second = key_idx;
        end
        start = 1'b0;
        res = blk_out;
    endtask

    task automatic after_done(input string req, input logic [127:0] res);
        @(negedge clk);
        chk({req, " R8 done one cycle"}, 128'(done), 128'(0));
        chk({req, " R9 output held"}, blk_out, res);
        repeat (4) @(negedge clk);
        chk({req, " R9 output held later"}, blk_out, res);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] ct, pt, res, exp;
        int lat;

        fill_keys(1'b1);
        blk_in = 128'hdead_beef;
        repeat (3) @(negedge clk);
        // R1: during reset
        chk("R1 done in reset", 128'(done), 128'(0));
        chk("R1 out in reset", blk_out, 128'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done after reset", 128'(done), 128'(0));
        chk("R1 out after reset", blk_out, 128'h0);
        chk("R1 key index after reset", 128'(key_idx), 128'(0));

        // R11: zero keys keep a zero block zero
        run_op(1'b0, 128'h0, 1'b0, res, lat);
        chk("R11 zero encrypt", res, 128'h0);
        run_op(1'b1, 128'h0, 1'b0, res, lat);
        chk("R11 zero decrypt", res, 128'h0);

        // Table walk: R2 R3 R6 encryption, R4 decryption, R5 round trip
        for (int v = 0; v < 6; v++) begin
            fill_keys(1'b0);
            pt = VEC[v];
            exp = ref_enc(pt);
            run_op(1'b0, pt, 1'b0, ct, lat);
            chk("R2 R3 R6 encrypt result", ct, exp);
            chk("R8 encrypt latency", 128'(lat), 128'(24));
            chk("R7 encrypt first index", 128'(idx_first), 128'(0));
            chk("R7 encrypt second index", 128'(idx_second), 128'(1));
            after_done("encrypt", ct);
            run_op(1'b1, ct, 1'b0, res, lat);
            chk("R5 round trip", res, pt);
            chk("R7 decrypt first index", 128'(idx_first), 128'(21));
            chk("R7 decrypt second index", 128'(idx_second), 128'(20));
            run_op(1'b1, pt, 1'b0, res, lat);
            chk("R4 decrypt result", res, ref_dec(pt));
            chk("R8 decrypt latency", 128'(lat), 128'(24));
        end

        // R10: start while busy is ignored (mode and block both changed)
        fill_keys(1'b0);
        pt = 128'hcafef00d_12345678_9abcdef0_0badf00d;
        run_op(1'b0, pt, 1'b1, res, lat);
        chk("R10 start ignored result", res, ref_enc(pt));
        chk("R10 start ignored latency", 128'(lat), 128'(24));
        after_done("R10", res);

        // R5 with several further random keys and blocks
        for (int n = 0; n < 4; n++) begin
            fill_keys(1'b0);
            pt = {$urandom, $urandom, $urandom, $urandom};
            run_op(1'b0, pt, 1'b0, ct, lat);
            run_op(1'b1, ct, 1'b0, res, lat);
            chk("R5 random round trip", res, pt);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule